// File: doc/BRIEF.md
# Speculative Load Address Table

This block lets a load be hoisted above stores that might write the same bytes. When an advanced load issues, the table records an entry for that load. The entry holds the load's destination register tag, the 8-byte granule it reads, and the bytes it touches within that granule. Every store compares its own granule and byte span against all live entries and clears those it overlaps. A later check names the destination register. It reports whether the speculative value may still be used, or whether the recovery path must run.

Each table row is a small two-state machine: `SLOT_EMPTY` and `SLOT_ARMED`. `SLOT_EMPTY` goes to `SLOT_ARMED` when a load is written to the row, and a flush in the same cycle blocks this. `SLOT_ARMED` stays in `SLOT_ARMED` on a reload, which replaces the row's contents. `SLOT_ARMED` goes to `SLOT_EMPTY` on a flush or on an overlapping store that is not paired with a reload of that row. The check result is held by a three-state response machine: `RESP_NONE`, `RESP_PASS` and `RESP_RECOVER`. Each cycle it enters `RESP_PASS` or `RESP_RECOVER` when a check was presented, and `RESP_NONE` otherwise.

A row is chosen by the register tag modulo the table depth. The depth must be a power of two. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Bytes that would run past the end of the 8-byte granule are not compared.

Top module: `spec_ld_table`

## Requirements
- R1: After reset every row is empty, and `chk_pass`, `chk_recover` and `tbl_full` are low.
- R2: A load with tag T writes row T mod DEPTH. A check of T with no conflict in between raises `chk_pass` in the cycle after the check.
- R3: A new load to the same row replaces the old entry. A check of the old tag that shares the row then raises `chk_recover`, and a check of the new tag passes.
- R4: A store in the same granule (address bits above bit 2) whose byte span overlaps the entry's span, even partly, clears the entry. A later check raises `chk_recover`.
- R5: A store in another granule, or with a disjoint byte span in the same granule, leaves the entry intact, and a later check passes.
- R6: A check of a tag that has no valid entry with an equal stored tag raises `chk_recover`.
- R7: When a store and a check arrive in the same cycle, the store's clearing is applied first. A check hit by that store fails.
- R8: `flush` empties every row and overrides a load in the same cycle. A check in the same cycle as a flush fails.
- R9: `tbl_full` is high exactly when every row holds a valid entry.
- R10: In the cycle after each check, exactly one of `chk_pass` and `chk_recover` is high. Both are low in the cycle after a cycle without a check.
- R11: A load in the same cycle as an overlapping store keeps its new entry. A check in the same cycle as a load sees the row's earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Clears every row |
| ld_valid | input | 1 | Advanced load request |
| ld_tag | input | TAG_W | Destination register of the load |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_size | input | 2 | Load size code |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_tag | input | TAG_W | Register tag being checked |
| chk_pass | output | 1 | Speculation held, one cycle after the check |
| chk_recover | output | 1 | Recovery required, one cycle after the check |
| tbl_full | output | 1 | Every row holds a valid entry |

## Verification
The hardest cases to reach are same-cycle collisions. These are a store clearing the very row being checked, a load and an overlapping store landing together, and two tags that alias to one row. Random traffic rarely produces them. Directed steps therefore build each one by hand: tags are chosen to alias modulo the depth, and store offsets are chosen to hit or just miss the loaded byte span. A long random phase then reuses a small pool of tags and granules so that these collisions recur, with a behavioural model checking every cycle.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_ARMED
    } slot_state_t;

    typedef enum logic [1:0] {
        RESP_NONE,
        RESP_PASS,
        RESP_RECOVER
    } resp_state_t;

    // Byte lanes of an 8-byte granule covered by an access; lanes past 7 drop.
    function automatic logic [7:0] span_mask(input logic [2:0] off, input logic [1:0] sz);
        logic [15:0] w;
        w = ((16'd1 << (5'd1 << sz)) - 16'd1) << off;
        return w[7:0];
    endfunction

endpackage

// File: rtl/spec_ld_slot.sv
module spec_ld_slot
    import spec_ld_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int GRAN_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [GRAN_W-1:0] wr_gran,
    input  logic [7:0]        wr_mask,
    input  logic              st_valid,
    input  logic [GRAN_W-1:0] st_gran,
    input  logic [7:0]        st_mask,
    output logic              armed,
    output logic              live,
    output logic [TAG_W-1:0]  tag
);

    slot_state_t       state_q, state_d;
    logic [GRAN_W-1:0] gran_q;
    logic [7:0]        mask_q;
    logic              st_hit;

    assign st_hit = (state_q == SLOT_ARMED) && st_valid
                    && (gran_q == st_gran) && ((mask_q & st_mask) != 8'd0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (!flush && wr_en) state_d = SLOT_ARMED;
            end
            SLOT_ARMED: begin
                if (flush)       state_d = SLOT_EMPTY;
                else if (wr_en)  state_d = SLOT_ARMED;
                else if (st_hit) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag    <= '0;
            gran_q <= '0;
            mask_q <= '0;
        end else if (wr_en && !flush) begin
            tag    <= wr_tag;
            gran_q <= wr_gran;
            mask_q <= wr_mask;
        end
    end

    assign armed = (state_q == SLOT_ARMED);
    assign live  = armed && !st_hit && !flush;

endmodule

// File: rtl/spec_ld_resp.sv
module spec_ld_resp
    import spec_ld_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_valid,
    input  logic hit,
    output logic chk_pass,
    output logic chk_recover
);

    resp_state_t state_q, state_d;

    always_comb begin
        state_d = RESP_NONE;
        if (chk_valid) state_d = hit ? RESP_PASS : RESP_RECOVER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESP_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        chk_pass    = 1'b0;
        chk_recover = 1'b0;
        unique case (state_q)
            RESP_NONE:    ;
            RESP_PASS:    chk_pass    = 1'b1;
            RESP_RECOVER: chk_recover = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
    import spec_ld_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 7,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_pass,
    output logic              chk_recover,
    output logic              tbl_full
);

    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int GRAN_W = ADDR_W - 3;

    logic [DEPTH-1:0] armed;
    logic [DEPTH-1:0] live;
    logic [TAG_W-1:0] row_tag [DEPTH];
    logic [IDX_W-1:0] ld_idx;
    logic [IDX_W-1:0] chk_idx;
    logic [7:0]       ld_mask;
    logic [7:0]       st_mask;
    logic             hit;

    assign ld_idx  = ld_tag[IDX_W-1:0];
    assign chk_idx = chk_tag[IDX_W-1:0];
    assign ld_mask = span_mask(ld_addr[2:0], ld_size);
    assign st_mask = span_mask(st_addr[2:0], st_size);

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        spec_ld_slot #(
            .TAG_W  (TAG_W),
            .GRAN_W (GRAN_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (ld_valid && (ld_idx == IDX_W'(g))),
            .wr_tag   (ld_tag),
            .wr_gran  (ld_addr[ADDR_W-1:3]),
            .wr_mask  (ld_mask),
            .st_valid (st_valid),
            .st_gran  (st_addr[ADDR_W-1:3]),
            .st_mask  (st_mask),
            .armed    (armed[g]),
            .live     (live[g]),
            .tag      (row_tag[g])
        );
    end

    assign hit      = live[chk_idx] && (row_tag[chk_idx] == chk_tag);
    assign tbl_full = &armed;

    spec_ld_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_valid   (chk_valid),
        .hit         (hit),
        .chk_pass    (chk_pass),
        .chk_recover (chk_recover)
    );

endmodule

// File: rtl/spec_ld_chk.sv
module spec_ld_chk #(
    parameter int TAG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             ld_valid,
    input logic [TAG_W-1:0] ld_tag,
    input logic             st_valid,
    input logic             chk_valid,
    input logic [TAG_W-1:0] chk_tag,
    input logic             chk_pass,
    input logic             chk_recover,
    input logic             tbl_full
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_pass && chk_recover)); // R10

    AST_RESULT_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (chk_pass || chk_recover)); // R10

    AST_QUIET_WITHOUT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!chk_pass && !chk_recover)); // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !tbl_full); // R8

    AST_FLUSH_FAILS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && chk_valid) |=> chk_recover); // R8

    AST_LOAD_THEN_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !st_valid && !flush && !ld_valid && $past(ld_valid && !flush)
         && (chk_tag == $past(ld_tag))) |=> chk_pass); // R2

endmodule

bind spec_ld_table spec_ld_chk #(.TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .ld_valid    (ld_valid),
    .ld_tag      (ld_tag),
    .st_valid    (st_valid),
    .chk_valid   (chk_valid),
    .chk_tag     (chk_tag),
    .chk_pass    (chk_pass),
    .chk_recover (chk_recover),
    .tbl_full    (tbl_full)
);

// File: tb/spec_ld_table_tb.sv
module spec_ld_table_tb;

    localparam int DEPTH  = 8;
    localparam int TAG_W  = 7;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              ld_valid = 1'b0;
    logic [TAG_W-1:0]  ld_tag = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [1:0]        ld_size = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic              chk_valid = 1'b0;
    logic [TAG_W-1:0]  chk_tag = '0;
    logic              chk_pass;
    logic              chk_recover;
    logic              tbl_full;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    spec_ld_table #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_pass(chk_pass), .chk_recover(chk_recover), .tbl_full(tbl_full)
    );

    // Behavioural reference: per row valid, tag, granule and byte range [lo,hi).
    int m_v   [DEPTH];
    int m_tag [DEPTH];
    longint m_gr [DEPTH];
    int m_lo  [DEPTH];
    int m_hi  [DEPTH];
    int e_pass = 0, e_rec = 0, e_full = 0;

    function automatic int lo_of(logic [ADDR_W-1:0] a);
        return int'(a % 8);
    endfunction
    function automatic int hi_of(logic [ADDR_W-1:0] a, logic [1:0] s);
        int h;
        h = int'(a % 8) + (1 << s);
        return (h > 8) ? 8 : h;
    endfunction

    function automatic bit overlaps(int r);
        longint sg;
        int sl, sh;
        sg = longint'(st_addr / 8);
        sl = lo_of(st_addr);
        sh = hi_of(st_addr, st_size);
        return (m_gr[r] == sg) && (sl < m_hi[r]) && (m_lo[r] < sh);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) m_v[r] = 0;
            e_pass = 0; e_rec = 0; e_full = 0;
        end else begin
            int ci, li, full;
            ci = int'(chk_tag) % DEPTH;
            li = int'(ld_tag) % DEPTH;
            e_pass = (chk_valid && !flush && m_v[ci] != 0 && m_tag[ci] == int'(chk_tag)
                      && !(st_valid && overlaps(ci))) ? 1 : 0;
            e_rec  = (chk_valid && e_pass == 0) ? 1 : 0;
            if (flush) begin
                for (int r = 0; r < DEPTH; r++) m_v[r] = 0;
            end else begin
                if (st_valid)
                    for (int r = 0; r < DEPTH; r++)
                        if (m_v[r] != 0 && overlaps(r)) m_v[r] = 0;
                if (ld_valid) begin
                    m_v[li]   = 1;
                    m_tag[li] = int'(ld_tag);
                    m_gr[li]  = longint'(ld_addr / 8);
                    m_lo[li]  = lo_of(ld_addr);
                    m_hi[li]  = hi_of(ld_addr, ld_size);
                end
            end
            full = 1;
            for (int r = 0; r < DEPTH; r++) if (m_v[r] == 0) full = 0;
            e_full = full;
        end
        #2;
        check("R10 pass", int'(chk_pass), e_pass);
        check("R10 recover", int'(chk_recover), e_rec);
        check("R9 full", int'(tbl_full), e_full);
    end

    task automatic idle_in();
        flush = 0; ld_valid = 0; st_valid = 0; chk_valid = 0;
    endtask

    // Present one cycle of stimulus at a falling edge; return at the next falling edge.
    task automatic step(bit fl, bit ld, int lt, int la, int ls,
                        bit st, int sa, int ss, bit ck, int ct);
        flush = fl;
        ld_valid = ld; ld_tag = TAG_W'(lt); ld_addr = ADDR_W'(la); ld_size = 2'(ls);
        st_valid = st; st_addr = ADDR_W'(sa); st_size = 2'(ss);
        chk_valid = ck; chk_tag = TAG_W'(ct);
        @(negedge clk);
        idle_in();
    endtask

    task automatic ld1(int t, int a, int s);
        step(0, 1, t, a, s, 0, 0, 0, 0, 0);
    endtask
    task automatic st1(int a, int s);
        step(0, 0, 0, 0, 0, 1, a, s, 0, 0);
    endtask
    task automatic ck1(int t);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, t);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pass", int'(chk_pass), 0);
        check("R1 recover", int'(chk_recover), 0);
        check("R1 full", int'(tbl_full), 0);
        rst_n = 1'b1;
        @(negedge clk);

        ld1(5, 'h100, 3); ck1(5);
        check("R2 pass after load", int'(chk_pass), 1);

        st1('h108, 3); ck1(5);
        check("R5 other granule", int'(chk_pass), 1);
        ld1(5, 'h100, 1); st1('h104, 2); ck1(5);
        check("R5 disjoint bytes", int'(chk_pass), 1);

        st1('h101, 0); ck1(5);
        check("R4 partial overlap", int'(chk_recover), 1);

        ck1(9);
        check("R6 no entry", int'(chk_recover), 1);

        ld1(3, 'h300, 3); ld1(11, 'h340, 3); ck1(3);
        check("R3 evicted tag", int'(chk_recover), 1);
        ck1(11);
        check("R3 new tag", int'(chk_pass), 1);

        ld1(2, 'h200, 2);
        step(0, 0, 0, 0, 0, 1, 'h202, 0, 1, 2);
        check("R7 store first", int'(chk_recover), 1);

        step(0, 1, 4, 'h400, 3, 1, 'h400, 3, 0, 0); ck1(4);
        check("R11 load beats store", int'(chk_pass), 1);
        step(0, 1, 12, 'h480, 3, 0, 0, 0, 1, 12);
        check("R11 check sees old row", int'(chk_recover), 1);

        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R10 no check", int'(chk_pass | chk_recover), 0);

        for (int t = 0; t < DEPTH; t++) ld1(t, 'h1000 + 8 * t, 3);
        check("R9 full", int'(tbl_full), 1);
        step(1, 1, 1, 'h2000, 3, 0, 0, 0, 1, 0);
        check("R8 flush fails check", int'(chk_recover), 1);
        check("R8 flush empties", int'(tbl_full), 0);
        ck1(1);
        check("R8 flush beats load", int'(chk_recover), 1);

        for (int n = 0; n < 3000; n++) begin
            int sz, ssz;
            sz  = $urandom_range(0, 3);
            ssz = $urandom_range(0, 3);
            step($urandom_range(0, 99) == 0,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 19),
                 8 * $urandom_range(0, 3) + ((1 << sz) * $urandom_range(0, (8 >> sz) - 1)), sz,
                 $urandom_range(0, 2) == 0,
                 8 * $urandom_range(0, 3) + ((1 << ssz) * $urandom_range(0, (8 >> ssz) - 1)), ssz,
                 $urandom_range(0, 1) == 0, $urandom_range(0, 19));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule